// File: doc/BRIEF.md
# Three-Channel DMA Request Sequencer

This block lets three I/O devices share one memory DMA channel. Each device raises a break request and marks whether it can run at full speed and which way its data flows. The sequencer picks one requester, asks memory for a cycle, and then takes the chosen channel through a syncing time state and a data-transfer time state. The two internal phase pulses, A and D, drive every step. Strobes back to the device report that the fast request was consumed, that the address was taken, that the data word is ready, and that input data was accepted.

A channel that does not raise its fast flag gets a slow cycle. One extra A/D phase pair is inserted before the data-ready strobe, which gives slow device logic time for its data lines to settle. A channel that keeps its break request asserted during a fast transfer is synced again while its current word is still moving. Successive words therefore run back to back with no idle syncing state between them. The memory controller and the data register sit outside the block. The sequencer only hands them a request line, a register load pulse, a sense-amplifier select and the per-channel address and data select enables.

Top module: `brk_dma_seq`

## Requirements
- R1: An active-low asynchronous reset clears every per-channel flag and the slow flag. After reset `mem_req`, `sel_dev`, `sel_addr` and all device strobes are 0.
- R2: A channel's sync flag is set only at a D phase edge where its `brk_req` is 1, the slow flag is clear and no sync flag is already set. `mem_req` is 1 from the next cycle for as long as any sync flag is set.
- R3: When several channels request at the same D phase, the lowest index wins (0 before 1 before 2), and at most one sync flag is ever set.
- R4: An A phase with `mem_sync` high clears the set sync flag, sets that channel's address flag and gives a one-cycle `fast_clr` pulse to that channel in the same cycle. An A phase with `mem_sync` low leaves the sync flag and `mem_req` unchanged and gives no pulse.
- R5: A D phase with `mem_sync` high sets the data flag of a channel whose address flag is set. From then until the address is accepted, `sel_addr` of that channel is 1. The next A phase gives `addr_acc` for a channel whose address and data flags are both set, and clears its address flag unless it is re-synced in that same phase.
- R6: For a fast single transfer, the D phase after `addr_acc` gives `data_rdy` and clears the data flag. The transfer then produces no further strobes.
- R7: If the winning channel's `fast_req` is 0 at the D phase that sets its sync flag, the slow flag is set and blocks any new sync. It is cleared by an A phase that sees a channel with its data flag set and its address flag clear. `data_rdy` is given only at a D phase with the slow flag clear, so a slow transfer takes one extra A/D pair.
- R8: A fast channel that holds `brk_req` is synced again at the D phase that sets its data flag. This yields a second `fast_clr` in the same A phase as the first `addr_acc`, and two `addr_acc` / `data_rdy` pairs in total.
- R9: `data_acc` pulses with `data_rdy` for a channel whose `dev_to_mem` is 1. `sa_sel` is `mem_strobe` ANDed with any channel that has its data flag set and `dev_to_mem` 0.
- R10: `sel_dev` of a channel is 1 from the cycle after its `addr_acc` until its `data_rdy`; at most one bit of `sel_dev` is set.
- R11: `reg_load` is 1 in any cycle where `mem_grant` or `mem_strobe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power clear |
| brk_req | input | NCH | Per-channel break (service) request |
| fast_req | input | NCH | Per-channel fast-speed flag |
| dev_to_mem | input | NCH | Per-channel direction, 1 = device supplies data |
| mem_sync | input | 1 | Memory acknowledge that the DMA request is synced |
| mem_grant | input | 1 | Memory grant pulse |
| mem_strobe | input | 1 | Memory data strobe pulse |
| ph_a | input | 1 | A phase pulse, one cycle wide |
| ph_d | input | 1 | D phase pulse, one cycle wide, never with ph_a |
| mem_req | output | 1 | Memory access request |
| fast_clr | output | NCH | Per-channel fast-request clear strobe |
| addr_acc | output | NCH | Per-channel address-accepted strobe |
| data_rdy | output | NCH | Per-channel data-ready strobe |
| data_acc | output | NCH | Per-channel data-accepted strobe |
| sel_dev | output | NCH | One-hot data-word select toward the data register |
| sel_addr | output | NCH | Address select toward the data register |
| reg_load | output | 1 | Data register load pulse |
| sa_sel | output | 1 | Sense-amplifier select for memory-to-device words |

## Verification
The hardest situation to reach is the back-to-back fast case. There the channel's own re-sync, the second fast-clear and the first address acceptance must all fall in one A phase, while the data flag is held across the next D phase instead of being cleared. The stimulus reaches it by keeping the break request of a fast channel asserted across its data-flag D phase and holding memory sync high. It releases the request only after the second fast-clear. A slow transfer is also used while a higher-priority request waits. This shows that the slow flag holds off the new sync until the stretched word has completed.

// File: rtl/brk_dma_seq.sv
module brk_dma_seq #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] brk_req,
  input  logic [NCH-1:0] fast_req,
  input  logic [NCH-1:0] dev_to_mem,
  input  logic           mem_sync,
  input  logic           mem_grant,
  input  logic           mem_strobe,
  input  logic           ph_a,
  input  logic           ph_d,
  output logic           mem_req,
  output logic [NCH-1:0] fast_clr,
  output logic [NCH-1:0] addr_acc,
  output logic [NCH-1:0] data_rdy,
  output logic [NCH-1:0] data_acc,
  output logic [NCH-1:0] sel_dev,
  output logic [NCH-1:0] sel_addr,
  output logic           reg_load,
  output logic           sa_sel
);

  logic [NCH-1:0] sync_f, adr_f, dat_f, dev_ctl;
  logic           slow;
  logic [NCH-1:0] sync_en, win;
  logic           any_sync;

  assign any_sync = |sync_f;
  assign sync_en  = brk_req & {NCH{~slow}};

  // fixed priority: lowest index wins (R3)
  always_comb begin
    logic taken;
    taken = 1'b0;
    win   = '0;
    for (int i = 0; i < NCH; i++) begin
      win[i] = sync_en[i] & ~taken;
      taken  = taken | sync_en[i];
    end
  end

  assign fast_clr = {NCH{ph_a & mem_sync}} & sync_f;
  assign addr_acc = {NCH{ph_a}} & adr_f & dat_f;
  assign data_rdy = {NCH{ph_d & ~slow}} & dat_f;
  assign data_acc = data_rdy & dev_to_mem;
  assign sel_dev  = dat_f & dev_ctl;
  assign sel_addr = dat_f & ~dev_ctl;
  assign mem_req  = any_sync;
  assign reg_load = mem_grant | mem_strobe;
  assign sa_sel   = mem_strobe & |(dat_f & ~dev_to_mem);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_f  <= '0;
      adr_f   <= '0;
      dat_f   <= '0;
      dev_ctl <= '0;
      slow    <= 1'b0;
    end else if (ph_d) begin
      if (!any_sync) begin
        sync_f <= win;
        if (|(win & ~fast_req)) slow <= 1'b1;
      end
      for (int i = 0; i < NCH; i++) begin
        if (adr_f[i] && mem_sync) dat_f[i] <= 1'b1;
        else if (!adr_f[i] && !slow) dat_f[i] <= 1'b0;
      end
      dev_ctl <= dev_ctl & ~data_rdy;
    end else if (ph_a) begin
      for (int i = 0; i < NCH; i++) begin
        if (sync_f[i] && mem_sync) adr_f[i] <= 1'b1;
        else if (dat_f[i]) adr_f[i] <= 1'b0;
      end
      if (mem_sync) sync_f <= '0;
      dev_ctl <= dev_ctl | addr_acc;
      if (|(dat_f & ~adr_f)) slow <= 1'b0;
    end
  end

  AST_ONE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_f)); // R3

  AST_SYNC_ONLY_ON_D: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_d |=> !(|(sync_f & ~$past(sync_f)))); // R2

  AST_SLOW_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    slow |=> !(|(sync_f & ~$past(sync_f)))); // R7

  AST_FCLR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|fast_clr) |=> !mem_req); // R4

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_dev)); // R10

endmodule

// File: tb/test_brk_dma_seq.sv
`timescale 1ns/1ps
module test_brk_dma_seq;
  localparam int NCH = 3;
  localparam int K_FCLR = 0, K_AACC = 1, K_RDY = 2, K_DACC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] brk_req = '0, fast_req = '0, dev_to_mem = '0;
  logic mem_sync = 1'b0, mem_grant = 1'b0, mem_strobe = 1'b0, ph_a = 1'b0, ph_d = 1'b0;
  logic mem_req, reg_load, sa_sel;
  logic [NCH-1:0] fast_clr, addr_acc, data_rdy, data_acc, sel_dev, sel_addr;

  int ntot = 0, nbad = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  brk_dma_seq #(.NCH(NCH)) i_brk_dma_seq (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .fast_req(fast_req),
    .dev_to_mem(dev_to_mem), .mem_sync(mem_sync), .mem_grant(mem_grant),
    .mem_strobe(mem_strobe), .ph_a(ph_a), .ph_d(ph_d), .mem_req(mem_req),
    .fast_clr(fast_clr), .addr_acc(addr_acc), .data_rdy(data_rdy),
    .data_acc(data_acc), .sel_dev(sel_dev), .sel_addr(sel_addr),
    .reg_load(reg_load), .sa_sel(sa_sel));

  function automatic string kreq(int k);
    case (k)
      K_FCLR: return "R4";
      K_AACC: return "R5";
      K_RDY:  return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int ch);
    exp_q.push_back(kind * 4 + ch);
  endtask

  task automatic step_d;
    @(posedge clk); #1 ph_d = 1'b1;
    @(posedge clk); #1 ph_d = 1'b0;
  endtask

  task automatic step_a;
    @(posedge clk); #1 ph_a = 1'b1;
    @(posedge clk); #1 ph_a = 1'b0;
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        logic [3:0] hit;
        hit = {data_acc[c], data_rdy[c], addr_acc[c], fast_clr[c]};
        for (int k = 0; k < 4; k++) begin
          if (hit[k] === 1'b1) begin
            ntot++;
            if (exp_q.size() == 0) begin
              nbad++;
              $display("FAIL %s unexpected strobe kind%0d ch%0d act=pulse exp=none", kreq(k), k, c);
            end else begin
              int e;
              e = exp_q.pop_front();
              if (e != k * 4 + c) begin
                nbad++;
                $display("FAIL %s strobe mismatch act=%0d exp=%0d", kreq(k), k * 4 + c, e);
              end
            end
          end
        end
      end
    end
  end

  // fast transfer from the syncing D phase to completion, requests dropped after fast clear
  task automatic xfer_fast(input int ch, input bit d2m);
    step_d;
    @(negedge clk) chk("R2", "mem_req after sync", {7'd0, mem_req}, 8'd1);
    mem_sync = 1'b1;
    push(K_FCLR, ch);
    step_a;
    @(negedge clk) chk("R4", "mem_req after clear sync", {7'd0, mem_req}, 8'd0);
    brk_req = '0;
    step_d;
    @(negedge clk) chk("R5", "sel_addr after data flag", {5'd0, sel_addr}, 8'(1 << ch));
    mem_sync = 1'b0;
    push(K_AACC, ch);
    step_a;
    @(negedge clk) chk("R10", "sel_dev after addr_acc", {5'd0, sel_dev}, 8'(1 << ch));
    push(K_RDY, ch);
    if (d2m) push(K_DACC, ch);
    step_d;
    @(negedge clk) chk("R6", "sel_dev after ready", {5'd0, sel_dev | sel_addr}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "mem_req in reset", {7'd0, mem_req}, 8'd0);
    chk("R1", "selects in reset", {2'd0, sel_dev, sel_addr}, 8'd0);
    chk("R1", "strobes in reset", {4'd0, |fast_clr, |addr_acc, |data_rdy, |data_acc}, 8'd0);
    chk("R11", "reg_load idle", {7'd0, reg_load}, 8'd0);
    rst_n = 1'b1;

    // R2: request without D phase does nothing
    brk_req = 3'b001; fast_req = 3'b111; dev_to_mem = 3'b011;
    repeat (3) @(posedge clk);
    @(negedge clk) chk("R2", "no sync without D phase", {7'd0, mem_req}, 8'd0);

    // R4: A phase without mem_sync is ignored, then fast single input on ch0
    step_d;
    @(negedge clk) chk("R2", "mem_req ch0", {7'd0, mem_req}, 8'd1);
    step_a;
    @(negedge clk) chk("R4", "A without mem_sync keeps req", {7'd0, mem_req}, 8'd1);
    mem_sync = 1'b1;
    push(K_FCLR, 0);
    step_a;
    brk_req = '0;
    step_d;
    mem_sync = 1'b0;
    push(K_AACC, 0);
    step_a;
    @(negedge clk) chk("R10", "sel_dev ch0", {5'd0, sel_dev}, 8'd1);
    mem_strobe = 1'b1;
    @(negedge clk);
    chk("R9", "sa_sel off for device-to-memory", {7'd0, sa_sel}, 8'd0);
    chk("R11", "reg_load on strobe", {7'd0, reg_load}, 8'd1);
    mem_strobe = 1'b0;
    push(K_RDY, 0); push(K_DACC, 0);
    step_d;
    step_a; step_d;
    @(negedge clk) chk("R6", "idle after single", {7'd0, mem_req}, 8'd0);

    // R3: contention 0>1>2, then 1>2
    brk_req = 3'b111;
    xfer_fast(0, 1'b1);
    brk_req = 3'b110;
    xfer_fast(1, 1'b1);
    brk_req = 3'b100;
    xfer_fast(2, 1'b0);

    // R7: slow output on ch2 with a waiting request on ch0
    brk_req = 3'b100; fast_req = 3'b011;
    step_d;
    mem_sync = 1'b1;
    push(K_FCLR, 2);
    step_a;
    brk_req = '0;
    step_d;
    mem_sync = 1'b0;
    push(K_AACC, 2);
    step_a;
    @(negedge clk) chk("R10", "sel_dev ch2 slow", {5'd0, sel_dev}, 8'd4);
    mem_grant = 1'b1;
    @(negedge clk);
    chk("R11", "reg_load on grant", {7'd0, reg_load}, 8'd1);
    chk("R9", "sa_sel needs strobe", {7'd0, sa_sel}, 8'd0);
    mem_grant = 1'b0; mem_strobe = 1'b1;
    @(negedge clk) chk("R9", "sa_sel memory-to-device", {7'd0, sa_sel}, 8'd1);
    mem_strobe = 1'b0;
    brk_req = 3'b001;
    step_d;
    @(negedge clk) chk("R7", "slow holds off sync", {7'd0, mem_req}, 8'd0);
    brk_req = '0;
    step_a;
    push(K_RDY, 2);
    step_d;
    @(negedge clk) chk("R7", "slow word done", {5'd0, sel_dev | sel_addr}, 8'd0);
    fast_req = 3'b111;

    // R8: back-to-back fast on ch1
    brk_req = 3'b010;
    step_d;
    mem_sync = 1'b1;
    push(K_FCLR, 1);
    step_a;
    step_d;
    @(negedge clk) chk("R8", "re-sync during data", {7'd0, mem_req}, 8'd1);
    push(K_FCLR, 1); push(K_AACC, 1);
    step_a;
    brk_req = '0;
    @(negedge clk) chk("R8", "sel_dev word1", {5'd0, sel_dev}, 8'd2);
    push(K_RDY, 1); push(K_DACC, 1);
    step_d;
    @(negedge clk) chk("R8", "sel_addr word2", {5'd0, sel_addr}, 8'd2);
    mem_sync = 1'b0;
    push(K_AACC, 1);
    step_a;
    push(K_RDY, 1); push(K_DACC, 1);
    step_d;
    step_a; step_d;
    @(negedge clk);
    chk("R8", "idle after burst", {7'd0, mem_req}, 8'd0);
    chk("R8", "selects after burst", {2'd0, sel_dev, sel_addr}, 8'd0);
    chk("R6", "expected strobes left", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      ntot++; nbad++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end
endmodule